// File: doc/BRIEF.md
# Serial Register-Access Control Port

This block is a four-wire serial slave that lets a host controller read and write a bank of 8-bit control registers. The host pulls chip select low, clocks bytes in on the data-in line, and gets register contents back on the data-out line. The first byte of every transaction is a chip-address byte whose low bit chooses read or write. A write continues with a pointer byte, holding an auto-increment flag and a register address, and then any number of data bytes. A read starts returning register contents at the stored pointer right after the chip-address byte.

The serial pins are taken into the system clock domain through two-flop synchronizers and edge-detected, so the system clock must run several times faster than the serial clock. Register storage stays outside the block: a combinational read port (address out, data in) and a one-cycle write strobe connect it to any register file. Pointer stepping is strictly linear, so a burst can walk past the last defined register. Writes there are dropped and reads there return zero.

Top module: `spiRegPort`

## Requirements
- R1: While and after reset, with chip select high, the data-out enable `misoEn` is 0 and the write strobe `regWe` is 0.
- R2: Bits are sampled on the rising serial-clock edge, most significant bit first. The first byte must equal 7'b0010000 followed by the read/write bit (0x20 write, 0x21 read). Any other value makes the block ignore the rest of the transaction: no write strobe and no data-out drive until chip select rises.
- R3: In a write, the second byte is the pointer: bit 7 is the auto-increment flag and bits 6:0 are the register address. Each later byte gives one `regWe` pulse of one cycle, with `regAddr` at the pointer and `regWrData` equal to the byte.
- R4: In a read (read/write bit 1), the register at the pointer is returned. Its most significant bit is driven from the first falling serial-clock edge after the chip-address byte, and one bit follows per falling edge.
- R5: `misoEn` is 1 only from that first falling edge of read data until chip select rises. It stays 0 for the whole of a write transaction. `miso` is high impedance whenever `misoEn` is 0.
- R6: With the auto-increment flag set, successive data bytes of a read or write burst use consecutive addresses. With it clear, every byte uses the same address.
- R7: Pointer stepping is linear past 0x1F. A write to any address 0x20 or above raises no `regWe` and leaves the registers unchanged. Registers 0x00 to 0x1F are defined.
- R8: A read from an address 0x20 or above returns 0x00, whatever the register file presents.
- R9: Raising chip select mid-byte aborts the transaction: `misoEn` drops and the bit count restarts, so the next transaction is aligned. The pointer and its flag keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, high impedance when not driven |
| misoEn | output | 1 | High while `miso` is driven |
| regAddr | output | 7 | Register address (pointer) |
| regWe | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Register write data |
| regRdData | input | 8 | Register read data for `regAddr` |

## Verification
The register file in the bench answers 0xEE for every address from 0x20 upward. A design that forwards that value instead of masking it reads back 0xEE where 0x00 is expected. An auto-increment burst starting at 0x1E crosses into undefined space: a design that wraps or saturates the pointer, or that still strobes writes there, corrupts 0x00/0x1F or shows stray write strobes. An abort after three bits, followed by a full read, catches a bit counter that is not cleared, because every later byte would come back shifted. A pointer that is lost on abort also shows up there. A wrong chip address and a no-increment burst are also run: the first must leave the registers untouched, and the second must repeat one register rather than stepping.

// File: rtl/spiRegPkg.sv
`timescale 1ns/1ps
package spiRegPkg;
  typedef enum logic [2:0] {
    PH_ADDR,
    PH_PTR,
    PH_WDATA,
    PH_RDATA,
    PH_IGNORE
  } phase_e;

  typedef struct packed {
    logic sampleBit;
    logic loadPtr;
    logic writeData;
    logic loadTx;
    logic shiftTx;
    logic abort;
  } strobe_t;
endpackage

// File: rtl/spiRegSync.sv
`timescale 1ns/1ps
module spiRegSync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/spiRegCtrl.sv
`timescale 1ns/1ps
module spiRegCtrl
  import spiRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0010000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       sclkS,
  input  logic [7:0] rxNext,
  output strobe_t    stb
);
  phase_e     phase;
  logic [2:0] bitCnt;
  logic       sclkPrev;
  logic       rise;
  logic       fall;
  logic       byteDone;
  logic       addrMatch;

  always_comb begin
    rise      = !csS && sclkS && !sclkPrev;
    fall      = !csS && !sclkS && sclkPrev;
    byteDone  = rise && (bitCnt == 3'd7);
    addrMatch = (rxNext[7:1] == DEV_ADDR);
    stb           = '0;
    stb.abort     = csS;
    stb.sampleBit = rise;
    stb.shiftTx   = fall && (phase == PH_RDATA);
    if (byteDone) begin
      unique case (phase)
        PH_ADDR:  stb.loadTx    = addrMatch && rxNext[0];
        PH_PTR:   stb.loadPtr   = 1'b1;
        PH_WDATA: stb.writeData = 1'b1;
        PH_RDATA: stb.loadTx    = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_ADDR;
      bitCnt   <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      if (csS) begin
        phase  <= PH_ADDR;
        bitCnt <= '0;
      end else if (rise) begin
        bitCnt <= bitCnt + 3'd1;
        if (byteDone) begin
          unique case (phase)
            PH_ADDR: begin
              if (!addrMatch)    phase <= PH_IGNORE;
              else if (rxNext[0]) phase <= PH_RDATA;
              else               phase <= PH_PTR;
            end
            PH_PTR:  phase <= PH_WDATA;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spiRegData.sv
`timescale 1ns/1ps
module spiRegData
  import spiRegPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int NUM_REGS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              mosiS,
  input  logic [7:0]        regRdData,
  output logic [7:0]        rxNext,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWe,
  output logic [7:0]        regWrData,
  output logic              misoBit,
  output logic              misoEn
);
  localparam logic [ADDR_W:0] REG_LIMIT = (ADDR_W + 1)'(NUM_REGS);

  logic [6:0]        rxShift;
  logic [ADDR_W-1:0] ptr;
  logic              autoInc;
  logic [7:0]        txShift;
  logic              defined;
  logic [7:0]        rdByte;

  always_comb begin
    rxNext    = {rxShift, mosiS};
    defined   = ({1'b0, ptr} < REG_LIMIT);
    rdByte    = defined ? regRdData : 8'h00;
    regAddr   = ptr;
    regWe     = stb.writeData && defined;
    regWrData = rxNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      ptr     <= '0;
      autoInc <= 1'b0;
      txShift <= '0;
      misoBit <= 1'b0;
      misoEn  <= 1'b0;
    end else begin
      if (stb.sampleBit) rxShift <= rxNext[6:0];
      if (stb.loadPtr) begin
        ptr     <= rxNext[ADDR_W-1:0];
        autoInc <= rxNext[7];
      end else if ((stb.writeData || stb.loadTx) && autoInc) begin
        ptr <= ptr + 1'b1;
      end
      if (stb.loadTx) txShift <= rdByte;
      if (stb.abort) begin
        misoEn <= 1'b0;
      end else if (stb.shiftTx) begin
        misoBit <= txShift[7];
        txShift <= {txShift[6:0], 1'b0};
        misoEn  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spiRegPort.sv
`timescale 1ns/1ps
module spiRegPort
  import spiRegPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int NUM_REGS = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR = 7'b0010000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  output logic              misoEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWe,
  output logic [7:0]        regWrData,
  input  logic [7:0]        regRdData
);
  logic [2:0] pinsS;
  logic       csActive;
  logic       misoBit;
  logic [7:0] rxNext;
  strobe_t    stb;

  spiRegSync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) uSync (
    .clk(clk), .rstN(rstN), .din({csN, sclk, mosi}), .dout(pinsS)
  );

  assign csActive = !pinsS[2];

  spiRegCtrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .csS(pinsS[2]), .sclkS(pinsS[1]),
    .rxNext(rxNext), .stb(stb)
  );

  spiRegData #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .mosiS(pinsS[0]),
    .regRdData(regRdData), .rxNext(rxNext), .regAddr(regAddr),
    .regWe(regWe), .regWrData(regWrData), .misoBit(misoBit), .misoEn(misoEn)
  );

  assign miso = misoEn ? misoBit : 1'bz;
endmodule

// File: rtl/spiRegPortChk.sv
`timescale 1ns/1ps
module spiRegPortChk #(
  parameter int ADDR_W = 7,
  parameter int NUM_REGS = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              csActive,
  input logic              misoEn,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr
);
  a_r7_defined_write_only: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> ({1'b0, regAddr} < (ADDR_W + 1)'(NUM_REGS)));

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  a_r9_release_drops_drive: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> !misoEn);

  a_r5_drive_starts_selected: assert property (@(posedge clk) disable iff (!rstN)
    $rose(misoEn) |-> csActive);

  a_r5_no_write_while_driving: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (!misoEn && csActive));
endmodule

bind spiRegPort spiRegPortChk #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) uChk (
  .clk(clk), .rstN(rstN), .csActive(csActive), .misoEn(misoEn),
  .regWe(regWe), .regAddr(regAddr)
);

// File: tb/tb_spiRegPort.sv
`timescale 1ns/1ps
module tb_spiRegPort;
  localparam int HALF = 80;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       sclk = 1'b0;
  logic       mosi = 1'b0;
  wire        miso;
  logic       misoEn;
  logic [6:0] regAddr;
  logic       regWe;
  logic [7:0] regWrData;
  logic [7:0] regRdData;

  logic [7:0] mem [32];
  int         wrCount;
  int         undefWrites;
  int         checks = 0;
  int         errors = 0;
  logic       inWrite = 1'b0;
  logic       oeInWrite = 1'b0;
  logic [7:0] q [4];

  always #4 clk = ~clk;

  spiRegPort dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .miso(miso), .misoEn(misoEn), .regAddr(regAddr), .regWe(regWe),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  assign regRdData = (regAddr < 7'd32) ? mem[regAddr[4:0]] : 8'hEE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) mem[i] <= 8'hC0 + 8'(i);
      wrCount     <= 0;
      undefWrites <= 0;
    end else if (regWe) begin
      wrCount <= wrCount + 1;
      if (regAddr < 7'd32) mem[regAddr[4:0]] <= regWrData;
      else undefWrites <= undefWrites + 1;
    end
  end

  always @(negedge clk) if (inWrite && misoEn) oeInWrite = 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      #(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      #(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic csStart();
    csN = 1'b0;
    #(HALF);
  endtask

  task automatic csEnd();
    #(HALF);
    csN = 1'b1;
    #(HALF * 2);
  endtask

  task automatic wrBurst(input logic [7:0] p, input int n, input logic [7:0] d0,
                         input logic [7:0] d1, input logic [7:0] d2, input logic [7:0] d3);
    logic [7:0] dummy;
    logic [7:0] d [4];
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    inWrite = 1'b1;
    csStart();
    xfer(8'h20, dummy);
    xfer(p, dummy);
    for (int k = 0; k < n; k++) xfer(d[k], dummy);
    csEnd();
    inWrite = 1'b0;
  endtask

  task automatic rdBurst(input int n);
    logic [7:0] dummy;
    csStart();
    xfer(8'h21, dummy);
    for (int k = 0; k < n; k++) xfer(8'h00, q[k]);
    csEnd();
  endtask

  // {pointer byte, write data, expected readback}
  localparam logic [23:0] VEC [6] = '{
    {8'h03, 8'hA5, 8'hA5},
    {8'h1F, 8'h3C, 8'h3C},
    {8'h00, 8'hFF, 8'hFF},
    {8'h20, 8'h77, 8'h00},
    {8'h7F, 8'h12, 8'h00},
    {8'h10, 8'h00, 8'h00}
  };

  initial begin
    int wrBefore;
    logic [7:0] dummy;
    #20;
    chk("R1 misoEn in reset", 32'(misoEn), 32'd0);
    chk("R1 regWe in reset", 32'(regWe), 32'd0);
    #20 rstN = 1'b1;
    #(HALF);
    chk("R1 misoEn after reset", 32'(misoEn), 32'd0);
    chk("R1 regWe after reset", 32'(regWe), 32'd0);

    // table walk: write one byte, point back, read it
    for (int v = 0; v < 6; v++) begin
      wrBurst(VEC[v][23:16], 1, VEC[v][15:8], 8'h00, 8'h00, 8'h00);
      wrBurst(VEC[v][23:16], 0, 8'h00, 8'h00, 8'h00, 8'h00);
      rdBurst(1);
      chk($sformatf("R3/R4/R8 vector %0d", v), 32'(q[0]), 32'(VEC[v][7:0]));
    end
    chk("R7 no strobe above 0x1F", 32'(undefWrites), 32'd0);
    chk("R5 no drive during writes", 32'(oeInWrite), 32'd0);

    // R4/R5: MSB driven after address byte
    wrBurst(8'h07, 1, 8'h5A, 8'h00, 8'h00, 8'h00);
    csStart();
    xfer(8'h21, dummy);
    #(HALF / 2);
    chk("R5 drive on after address byte", 32'(misoEn), 32'd1);
    chk("R4 MSB of reg 0x07", 32'(miso), 32'd0);
    #(HALF / 2);
    xfer(8'h00, dummy);
    chk("R4 reg 0x07 data", 32'(dummy), 32'h5A);
    csEnd();
    chk("R5 drive off after select release", 32'(misoEn), 32'd0);

    // R6: no-increment read repeats one register
    rdBurst(2);
    chk("R6 no-inc read byte 0", 32'(q[0]), 32'h5A);
    chk("R6 no-inc read byte 1", 32'(q[1]), 32'h5A);

    // R6: no-increment write lands on one register
    wrBurst(8'h0A, 2, 8'h01, 8'h02, 8'h00, 8'h00);
    chk("R6 no-inc write last byte kept", 32'(mem[10]), 32'h02);
    chk("R6 no-inc write neighbour untouched", 32'(mem[11]), 32'hCB);

    // R6/R7/R8: auto-increment burst crossing 0x1F
    wrBefore = wrCount;
    wrBurst(8'h9E, 4, 8'h11, 8'h22, 8'h33, 8'h44);
    chk("R6 inc write 0x1E", 32'(mem[30]), 32'h11);
    chk("R6 inc write 0x1F", 32'(mem[31]), 32'h22);
    chk("R7 only two strobes in burst", 32'(wrCount - wrBefore), 32'd2);
    chk("R7 reg 0x00 not wrapped", 32'(mem[0]), 32'hFF);
    chk("R7 reg 0x01 not wrapped", 32'(mem[1]), 32'hC1);
    wrBurst(8'h9E, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    rdBurst(4);
    chk("R6 inc read 0x1E", 32'(q[0]), 32'h11);
    chk("R6 inc read 0x1F", 32'(q[1]), 32'h22);
    chk("R8 inc read 0x20 is zero", 32'(q[2]), 32'h00);
    chk("R8 inc read 0x21 is zero", 32'(q[3]), 32'h00);

    // R2: wrong chip address ignored
    wrBefore = wrCount;
    csStart();
    xfer(8'h30, dummy);
    xfer(8'h02, dummy);
    xfer(8'h99, dummy);
    csEnd();
    chk("R2 wrong address no strobe", 32'(wrCount - wrBefore), 32'd0);
    chk("R2 wrong address reg 0x02 intact", 32'(mem[2]), 32'hC2);
    csStart();
    xfer(8'h23, dummy);
    #(HALF / 2);
    chk("R2 wrong read address no drive", 32'(misoEn), 32'd0);
    #(HALF / 2);
    csEnd();

    // R9: abort mid-byte, pointer kept, counter realigned
    wrBurst(8'h07, 0, 8'h00, 8'h00, 8'h00, 8'h00);
    csStart();
    xfer(8'h21, dummy);
    for (int i = 0; i < 3; i++) begin
      #(HALF); sclk = 1'b1; #(HALF); sclk = 1'b0;
    end
    csN = 1'b1;
    #(HALF);
    chk("R9 abort drops drive", 32'(misoEn), 32'd0);
    #(HALF);
    csStart();
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1; #(HALF); sclk = 1'b1; #(HALF); sclk = 1'b0;
    end
    csEnd();
    rdBurst(1);
    chk("R9 pointer kept and aligned", 32'(q[0]), 32'h5A);
    chk("R7 no undefined strobes overall", 32'(undefWrites), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule